// File: doc/BRIEF.md
# Multi-mode DUT trigger handshake

This block drives the trigger interface toward a single device under test. One engine serves four protocols, chosen by a two-bit mode input. The first two are asynchronous four-phase handshakes: the trigger line is held until the device answers with busy, and the engine then waits for busy to fall. The second of them also lets the device pull out the 32-bit trigger number, one bit per toggle of its own clock line. The other two are synchronous to the block clock: the trigger is a one-cycle pulse, and the device can hold triggers off with busy at any time. The last of them also shifts the trigger number out on the sync/T0 line straight after the pulse.

Trigger logic upstream offers a trigger request together with its number, and reads the registered veto flag to see whether the engine is occupied. A run-start pulse becomes a one-cycle timestamp-reset pulse on the sync/T0 line in the synchronous modes. Both device-side inputs (busy and the device clock line) pass through a flop synchroniser, so the device may run from an unrelated clock.

Top module: `dut_trig_hs`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `trig_out`, `sync_out` and `veto` are low.
- R2: `mode_sel` encodes 0 = async handshake, 1 = async handshake with number, 2 = sync pulse, 3 = sync pulse with number. It is taken only when a request is accepted in idle. A change during a transaction does not alter that transaction, and applies to the next one.
- R3: Async modes: an accepted request raises `trig_out` and `veto` on the next clock edge. `trig_out` stays high until the synchronised busy is seen high, and falls on the third rising edge after `dut_busy` rises. `veto` falls on the third rising edge after `dut_busy` falls.
- R4: Mode 1: after `trig_out` has fallen, each change of `dut_clk` (either direction) puts the next trigger-number bit, LSB first, on `sync_out` on the third rising edge after the change. `sync_out` holds that bit until the next change. Changes while `trig_out` is high are ignored, as are changes after all 32 bits have been sent.
- R5: Mode 1: the engine returns to idle (`veto` low, `sync_out` low) only once busy is low and all 32 bits have been sent. If busy falls earlier, `veto` stays high.
- R6: Sync modes: `trig_out` is high for exactly one cycle, starting on the edge after acceptance, and `veto` is high in that same cycle.
- R7: Sync modes: while the synchronised busy is high, requests are ignored and `veto` is high.
- R8: With a sync mode selected in idle, `run_start` gives a one-cycle high on `sync_out` on the next edge. With an async mode selected it has no effect.
- R9: Mode 3: bits 0 to 31 of the trigger number appear on `sync_out` in the 32 cycles right after the trigger pulse. `veto` stays high through the last bit and is low in the cycle after it.
- R10: A T0 request that arrives at the same time as an accepted request is emitted in the trigger cycle. One that arrives during a transaction is held, and emitted on the edge after the engine is next idle.
- R11: A request that arrives while a transaction is in progress is dropped. It never causes a later trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the clock sent to the device in the sync modes |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Protocol select (see R2) |
| trig_req | input | 1 | Trigger request from the trigger logic |
| trig_num | input | NUM_W | Trigger number, captured when a request is accepted |
| run_start | input | 1 | Start-of-run pulse that asks for a T0 |
| dut_busy | input | 1 | Busy line from the device (asynchronous) |
| dut_clk | input | 1 | Device-driven clock line used for number readout (asynchronous) |
| trig_out | output | 1 | Trigger line to the device |
| sync_out | output | 1 | Sync/T0 line: timestamp reset and serial trigger number |
| veto | output | 1 | High while the engine will not take a new trigger |

## Verification
The T0 pulse and trigger acceptance can fall in the same clock cycle, and both drive the device interface. The bench raises `run_start` and `trig_req` on the same edge in mode 3 and expects `trig_out` and `sync_out` both high in the next cycle, followed by the 32 serial bits unchanged. It also raises `run_start` in the middle of a serial transfer and expects the T0 pulse to wait until one cycle after the engine is idle again, so that it never corrupts a number bit.

// File: rtl/trig_hs_pkg.sv
package trig_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ATRIG,
    ST_AWAIT,
    ST_SPULSE,
    ST_SSHIFT
  } hs_state_e;

  // bit 1: synchronous protocol, bit 0: trigger number carried
  typedef enum logic [1:0] {
    MD_ASYNC     = 2'd0,
    MD_ASYNC_NUM = 2'd1,
    MD_SYNC      = 2'd2,
    MD_SYNC_NUM  = 2'd3
  } hs_mode_e;

endpackage

// File: rtl/trig_hs_sync.sv
module trig_hs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_st[s-1].r;
      end
    end
  end

  assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/trig_hs_shift.sv
module trig_hs_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  output logic         bit_out,
  output logic         done
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cnt <= '0;
    end else if (load) begin
      sr  <= load_val;
      cnt <= '0;
    end else if (shift_en && !done) begin
      sr  <= sr >> 1;
      cnt <= cnt + CW'(1);
    end
  end

  assign bit_out = sr[0];
  assign done    = (cnt == CW'(W));

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(W)); // R9

endmodule

// File: rtl/trig_hs_ctrl.sv
module trig_hs_ctrl
  import trig_hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       trig_req,
  input  logic       run_start,
  input  logic       busy_s,
  input  logic       dclk_s,
  input  logic       done,
  input  logic       bit_out,
  output logic       load,
  output logic       shift_en,
  output logic       trig_out,
  output logic       sync_out,
  output logic       veto
);

  hs_state_e state, state_n;
  hs_mode_e  mode_r;
  logic      dclk_q;
  logic      t0_pend;
  logic      accept;
  logic      t0_fire;
  logic      toggle;

  assign toggle  = dclk_s ^ dclk_q;
  assign accept  = (state == ST_IDLE) && trig_req && !busy_s;
  assign t0_fire = (state == ST_IDLE) && (run_start || t0_pend) && mode_sel[1];

  always_comb begin
    state_n  = state;
    load     = 1'b0;
    shift_en = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          load    = 1'b1;
          state_n = mode_sel[1] ? ST_SPULSE : ST_ATRIG;
        end
      end
      ST_ATRIG: begin
        if (busy_s) state_n = ST_AWAIT;
      end
      ST_AWAIT: begin
        if (mode_r == MD_ASYNC_NUM && toggle && !done) shift_en = 1'b1;
        if (!busy_s && (mode_r == MD_ASYNC || done)) state_n = ST_IDLE;
      end
      ST_SPULSE: begin
        if (mode_r == MD_SYNC_NUM) begin
          shift_en = 1'b1;
          state_n  = ST_SSHIFT;
        end else begin
          state_n  = ST_IDLE;
        end
      end
      ST_SSHIFT: begin
        if (done) state_n = ST_IDLE;
        else      shift_en = 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_r   <= MD_ASYNC;
      dclk_q   <= 1'b0;
      t0_pend  <= 1'b0;
      trig_out <= 1'b0;
      sync_out <= 1'b0;
      veto     <= 1'b0;
    end else begin
      state  <= state_n;
      dclk_q <= dclk_s;
      if (load) mode_r <= hs_mode_e'(mode_sel);
      t0_pend  <= (state != ST_IDLE) && (t0_pend || run_start);
      trig_out <= accept || ((state == ST_ATRIG) && !busy_s);
      if (shift_en)
        sync_out <= bit_out;
      else if (!(state == ST_AWAIT && state_n == ST_AWAIT))
        sync_out <= t0_fire;
      veto <= (state_n != ST_IDLE) || busy_s;
    end
  end

  AST_TRIG_VETOED: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> veto); // R3

  AST_ASYNC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trig_out && !mode_r[1] && !busy_s) |=> trig_out); // R3

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (trig_out && mode_r[1]) |=> !trig_out); // R6

  AST_RISE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(trig_out) |-> !$past(busy_s)); // R7

endmodule

// File: rtl/dut_trig_hs.sv
module dut_trig_hs #(
  parameter int NUM_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic             trig_req,
  input  logic [NUM_W-1:0] trig_num,
  input  logic             run_start,
  input  logic             dut_busy,
  input  logic             dut_clk,
  output logic             trig_out,
  output logic             sync_out,
  output logic             veto
);

  logic busy_s, dclk_s;
  logic load, shift_en, bit_out, done;

  trig_hs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({dut_clk, dut_busy}),
    .q   ({dclk_s, busy_s})
  );

  trig_hs_shift #(.W(NUM_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (trig_num),
    .shift_en (shift_en),
    .bit_out  (bit_out),
    .done     (done)
  );

  trig_hs_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mode_sel  (mode_sel),
    .trig_req  (trig_req),
    .run_start (run_start),
    .busy_s    (busy_s),
    .dclk_s    (dclk_s),
    .done      (done),
    .bit_out   (bit_out),
    .load      (load),
    .shift_en  (shift_en),
    .trig_out  (trig_out),
    .sync_out  (sync_out),
    .veto      (veto)
  );

endmodule

// File: tb/dut_trig_hs_test.sv
`timescale 1ns/1ps
module dut_trig_hs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd0;
  logic        trig_req = 1'b0;
  logic [31:0] trig_num = '0;
  logic        run_start = 1'b0;
  logic        dut_busy = 1'b0;
  logic        dut_clk = 1'b0;
  logic        trig_out, sync_out, veto;

  always #2.5 clk = ~clk;

  dut_trig_hs uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .trig_req(trig_req),
    .trig_num(trig_num), .run_start(run_start), .dut_busy(dut_busy),
    .dut_clk(dut_clk), .trig_out(trig_out), .sync_out(sync_out), .veto(veto)
  );

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;
  bit serial_on = 1'b0;
  logic [31:0] exp_q[$];

  task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: on each trigger rise with serial expected, compare next 32 bits
  initial begin
    logic prev_trig;
    logic [31:0] val;
    prev_trig = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && serial_on && trig_out && !prev_trig) begin
        if (exp_q.size() == 0) begin
          ck("R9 unexpected serial trigger", 32'd1, 32'd0);
        end else begin
          val = exp_q.pop_front();
          for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ck($sformatf("R9 serial bit %0d", i), {31'd0, sync_out}, {31'd0, val[i]});
          end
        end
      end
      prev_trig = trig_out;
    end
  end

  initial begin
    #1000000;
    ck("watchdog expired", 32'd1, 32'd0);
    finish_run();
  end

  task automatic sync_num(input logic [31:0] num, input bit collide, input bit extras);
    mode_sel = 2'd3;
    serial_on = 1'b1;
    exp_q.push_back(num);
    @(negedge clk);
    trig_req = 1'b1; trig_num = num; run_start = collide;
    @(negedge clk);
    trig_req = 1'b0; run_start = 1'b0;
    ck("R9 trigger pulse", {31'd0, trig_out}, 32'd1);
    if (collide) ck("R10 T0 with trigger", {31'd0, sync_out}, 32'd1);
    for (int n = 2; n <= 36; n++) begin
      @(negedge clk);
      if (extras) begin
        if (n == 5) trig_req = 1'b1;
        if (n == 6) begin
          ck("R11 req during shift", {31'd0, trig_out}, 32'd0);
          trig_req = 1'b0;
        end
        if (n == 7) ck("R11 req dropped", {31'd0, trig_out}, 32'd0);
        if (n == 10) run_start = 1'b1;
        if (n == 11) run_start = 1'b0;
        if (n == 35) ck("R10 deferred T0 high", {31'd0, sync_out}, 32'd1);
        if (n == 36) ck("R10 deferred T0 one cycle", {31'd0, sync_out}, 32'd0);
      end else if (n == 35) begin
        ck("R9 line idle after bits", {31'd0, sync_out}, 32'd0);
      end
      if (n == 33) ck("R9 veto through last bit", {31'd0, veto}, 32'd1);
      if (n == 34) ck("R9 veto low after bits", {31'd0, veto}, 32'd0);
    end
    serial_on = 1'b0;
  endtask

  task automatic async_num(input logic [31:0] num, input bit early);
    mode_sel = 2'd1;
    @(negedge clk);
    trig_req = 1'b1; trig_num = num;
    @(negedge clk);
    trig_req = 1'b0;
    ck("R3 mode1 trigger high", {31'd0, trig_out}, 32'd1);
    dut_clk = ~dut_clk;
    nedge(3);
    ck("R4 toggle while trigger high ignored", {31'd0, sync_out}, 32'd0);
    dut_busy = 1'b1;
    nedge(3);
    ck("R3 mode1 trigger low after busy", {31'd0, trig_out}, 32'd0);
    for (int i = 0; i < 32; i++) begin
      dut_clk = ~dut_clk;
      nedge(3);
      ck($sformatf("R4 readout bit %0d", i), {31'd0, sync_out}, {31'd0, num[i]});
      if (early && i == 9) dut_busy = 1'b0;
      if (early && i >= 12 && i < 31)
        ck("R5 veto held until all bits", {31'd0, veto}, 32'd1);
    end
    if (!early) begin
      dut_clk = ~dut_clk;
      nedge(3);
      ck("R4 extra toggle ignored", {31'd0, sync_out}, {31'd0, num[31]});
      ck("R5 veto while busy", {31'd0, veto}, 32'd1);
      dut_busy = 1'b0;
      nedge(3);
    end else begin
      nedge(2);
    end
    ck("R5 veto low at end", {31'd0, veto}, 32'd0);
    ck("R5 line low at end", {31'd0, sync_out}, 32'd0);
  endtask

  initial begin
    // R1 reset state
    trig_req = 1'b1;
    nedge(3);
    ck("R1 trig in reset", {31'd0, trig_out}, 32'd0);
    ck("R1 sync in reset", {31'd0, sync_out}, 32'd0);
    ck("R1 veto in reset", {31'd0, veto}, 32'd0);
    trig_req = 1'b0;
    rst = 1'b0;
    nedge(1);
    ck("R1 outputs after reset", {29'd0, trig_out, sync_out, veto}, 32'd0);

    // R6 sync pulse
    mode_sel = 2'd2;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); trig_req = 1'b1; trig_num = 32'h55 + k;
      @(negedge clk); trig_req = 1'b0;
      ck("R6 pulse high", {31'd0, trig_out}, 32'd1);
      ck("R6 veto with pulse", {31'd0, veto}, 32'd1);
      ck("R6 no serial in mode 2", {31'd0, sync_out}, 32'd0);
      @(negedge clk);
      ck("R6 pulse one cycle", {31'd0, trig_out}, 32'd0);
      ck("R6 veto released", {31'd0, veto}, 32'd0);
      nedge(2);
    end

    // R8 T0 pulse
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    ck("R8 T0 high", {31'd0, sync_out}, 32'd1);
    @(negedge clk);
    ck("R8 T0 one cycle", {31'd0, sync_out}, 32'd0);
    mode_sel = 2'd0;
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
    ck("R8 T0 ignored async", {31'd0, sync_out}, 32'd0);
    nedge(2);
    ck("R8 no later T0 async", {31'd0, sync_out}, 32'd0);

    // R7 busy veto in sync mode
    mode_sel = 2'd2;
    dut_busy = 1'b1;
    nedge(4);
    ck("R7 veto while busy", {31'd0, veto}, 32'd1);
    trig_req = 1'b1;
    @(negedge clk); trig_req = 1'b0;
    ck("R7 no trigger while busy", {31'd0, trig_out}, 32'd0);
    @(negedge clk);
    ck("R7 still no trigger", {31'd0, trig_out}, 32'd0);
    dut_busy = 1'b0;
    nedge(4);
    ck("R7 veto cleared", {31'd0, veto}, 32'd0);

    // R9, R10, R11 sync with number
    sync_num(32'hA5C3_0F96, 1'b0, 1'b1);
    nedge(3);
    sync_num(32'h8000_0001, 1'b1, 1'b0);
    nedge(3);

    // R3, R2 async handshake with mode change mid-transaction
    mode_sel = 2'd0;
    @(negedge clk); trig_req = 1'b1; trig_num = 32'h1234;
    @(negedge clk); trig_req = 1'b0;
    ck("R3 trigger high", {31'd0, trig_out}, 32'd1);
    ck("R3 veto high", {31'd0, veto}, 32'd1);
    mode_sel = 2'd2;
    nedge(4);
    ck("R2 mode change ignored mid-transaction", {31'd0, trig_out}, 32'd1);
    dut_busy = 1'b1;
    nedge(2);
    ck("R3 trigger held before sync busy", {31'd0, trig_out}, 32'd1);
    nedge(1);
    ck("R3 trigger low after busy", {31'd0, trig_out}, 32'd0);
    ck("R3 veto while busy", {31'd0, veto}, 32'd1);
    dut_busy = 1'b0;
    nedge(2);
    ck("R3 veto before sync release", {31'd0, veto}, 32'd1);
    nedge(1);
    ck("R3 veto released", {31'd0, veto}, 32'd0);
    @(negedge clk); trig_req = 1'b1;
    @(negedge clk); trig_req = 1'b0;
    ck("R2 new mode pulse high", {31'd0, trig_out}, 32'd1);
    @(negedge clk);
    ck("R2 new mode pulse one cycle", {31'd0, trig_out}, 32'd0);
    nedge(2);

    // R4, R5 async with number
    async_num(32'hC0FF_EE11, 1'b0);
    nedge(3);
    async_num(32'h0F0F_3C3C, 1'b1);
    nedge(5);
    if (exp_q.size() != 0) ck("R9 missing serial transfers", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule